// File: doc/BRIEF.md
# Two-Pass Feistel Round Function Unit

This block evaluates the 64-bit round function of a 128-bit Feistel cipher with only four byte-substitution boxes. A 64-bit half-block is first mixed with a 64-bit round key. Its eight bytes are then sent through the four boxes in two successive clock cycles, one 32-bit group per cycle. Each group's substituted bytes go through an XOR-only 64-bit diffusion layer, with the bytes of the other group set to zero. The two diffusion results are XOR-accumulated into the full round-function value. Because the diffusion layer is linear, this sum equals the result of a single 8-box evaluation.

A start strobe launches an operation and a done strobe marks the result two cycles later. In the optional round mode, the right half-block is folded into the accumulator, and the swapped half written out is the original left half. One accepted start therefore gives a complete Feistel round: the new left is R xor F(L, K) and the new right is L.

Top module: `feistel_f_unit`

## Requirements
- R1: The key-added value z = dataIn xor keyIn is the only input to substitution. Byte numbering is x1 = z[63:56] down to x8 = z[7:0].
- R2: Base box S1(a) = inv(a) xor 8'h6E. Here inv is the multiplicative inverse in GF(2^8) modulo x^8+x^4+x^3+x+1, with inv(0)=0. S2(a) = rotl1(S1(a)), S3(a) = rotr1(S1(a)), S4(a) = S1(rotl1(a)).
- R3: Byte assignment: y1=S1(x1), y2=S2(x2), y3=S3(x3), y4=S4(x4), y5=S2(x5), y6=S3(x6), y7=S4(x7), y8=S1(x8). The group x8,x7,x6,x5 is substituted in the first pass and the group x1,x4,x3,x2 in the second pass.
- R4: F = P(y), where P gives z1'..z8' (z1' is the top byte). z1'=y1^y3^y4^y6^y7^y8, z2'=y1^y2^y4^y5^y7^y8, z3'=y1^y2^y3^y5^y6^y8, z4'=y2^y3^y4^y5^y6^y7, z5'=y1^y2^y6^y7^y8, z6'=y2^y3^y5^y7^y8, z7'=y3^y4^y5^y6^y8, z8'=y1^y4^y5^y6^y7.
- R5: A start sampled while idle raises busy for exactly one cycle. It then raises done for exactly one cycle, in the second cycle after the accepting edge.
- R6: A start sampled while busy is high is ignored. Neither the result nor the timing of the running operation changes, and no extra done pulse follows.
- R7: In plain mode (roundMode=0) resOut equals F. In round mode (roundMode=1) resOut equals rightIn xor F. In both modes swapOut equals the dataIn captured at the accepting edge.
- R8: A synchronous active-high reset clears done, busy, resOut and swapOut.
- R9: resOut and swapOut hold their values from the done cycle until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch strobe, sampled with dataIn, keyIn, rightIn, roundMode |
| roundMode | input | 1 | 1: fold rightIn into the result (full Feistel round) |
| dataIn | input | 64 | Left half-block, the input to F |
| keyIn | input | 64 | Round key |
| rightIn | input | 64 | Right half-block, used in round mode |
| done | output | 1 | One-cycle result strobe |
| busy | output | 1 | High during the second pass |
| resOut | output | 64 | F, or rightIn xor F in round mode |
| swapOut | output | 64 | Captured left half (new right half) |

## Verification
One byte position at a time is swept through all 256 values, with every other data byte and the key at zero. This separates the eight box assignments, the four box variants and each byte's diffusion row. The same sweep is then applied to the key with zero data, which shows that the key enters only through the XOR in front of the boxes. Random half-blocks, keys and right halves in both modes check the accumulation of the two passes and the round-mode swap. A second start placed in the busy cycle checks that the running result survives and that no further done appears.

// File: rtl/feistel_f_pkg.sv
package feistel_f_pkg;
  localparam int HALF_W  = 64;
  localparam int BYTE_W  = 8;
  localparam int SLICE_W = HALF_W / 2;
  localparam int NSLOT   = SLICE_W / BYTE_W;
  localparam logic [BYTE_W-1:0] SBOX_CONST = 8'h6E;

  typedef struct packed {
    logic loadFirst;
    logic runSecond;
  } ffCtl_t;

  function automatic logic [7:0] gfMul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] sh;
    acc = '0;
    sh  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = {sh[6:0], 1'b0} ^ (sh[7] ? 8'h1B : 8'h00);
    end
    return acc;
  endfunction

  // a^254 by a squaring chain: a^2 * a^4 * ... * a^128
  function automatic logic [7:0] gfInv(input logic [7:0] a);
    logic [7:0] pw;
    logic [7:0] r;
    pw = a;
    r  = 8'h01;
    for (int i = 1; i < 8; i++) begin
      pw = gfMul(pw, pw);
      r  = gfMul(r, pw);
    end
    return r;
  endfunction

  function automatic logic [63:0] pLayer(input logic [63:0] y);
    logic [7:0] y1, y2, y3, y4, y5, y6, y7, y8;
    {y1, y2, y3, y4, y5, y6, y7, y8} = y;
    return {y1^y3^y4^y6^y7^y8,
            y1^y2^y4^y5^y7^y8,
            y1^y2^y3^y5^y6^y8,
            y2^y3^y4^y5^y6^y7,
            y1^y2^y6^y7^y8,
            y2^y3^y5^y7^y8,
            y3^y4^y5^y6^y8,
            y1^y4^y5^y6^y7};
  endfunction
endpackage

// File: rtl/ff_sbox.sv
module ff_sbox #(
  parameter int KIND = 1
) (
  input  logic [7:0] byteIn,
  output logic [7:0] byteOut
);
  import feistel_f_pkg::*;

  generate
    if (KIND == 4) begin : gRotIn
      always_comb byteOut = gfInv({byteIn[6:0], byteIn[7]}) ^ SBOX_CONST;
    end else begin : gRotOut
      logic [7:0] base;
      always_comb base = gfInv(byteIn) ^ SBOX_CONST;
      if (KIND == 2) begin : gLeft
        always_comb byteOut = {base[6:0], base[7]};
      end else if (KIND == 3) begin : gRight
        always_comb byteOut = {base[0], base[7:1]};
      end else begin : gPlain
        always_comb byteOut = base;
      end
    end
  endgenerate
endmodule

// File: rtl/ff_ctrl.sv
module ff_ctrl (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  output feistel_f_pkg::ffCtl_t ctl,
  output logic                  busy,
  output logic                  done
);
  logic secondPass;

  always_ff @(posedge clk) begin
    if (rst) begin
      secondPass <= 1'b0;
      done       <= 1'b0;
    end else begin
      secondPass <= start & ~secondPass;
      done       <= secondPass;
    end
  end

  always_comb begin
    ctl.loadFirst = start & ~secondPass;
    ctl.runSecond = secondPass;
    busy          = secondPass;
  end

  AST_DONE_TWO_LATER: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> ##1 done); // R5
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R5
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(busy)); // R5
  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> !busy); // R6
endmodule

// File: rtl/ff_datapath.sv
module ff_datapath (
  input  logic                             clk,
  input  logic                             rst,
  input  feistel_f_pkg::ffCtl_t            ctl,
  input  logic                             roundMode,
  input  logic [feistel_f_pkg::HALF_W-1:0] dataIn,
  input  logic [feistel_f_pkg::HALF_W-1:0] keyIn,
  input  logic [feistel_f_pkg::HALF_W-1:0] rightIn,
  output logic [feistel_f_pkg::HALF_W-1:0] resOut,
  output logic [feistel_f_pkg::HALF_W-1:0] swapOut
);
  import feistel_f_pkg::*;

  logic [SLICE_W-1:0] keyHiHeld;
  logic [SLICE_W-1:0] word;
  logic [BYTE_W-1:0]  slotIn  [NSLOT];
  logic [BYTE_W-1:0]  slotOut [NSLOT];
  logic [HALF_W-1:0]  yVec;
  logic [HALF_W-1:0]  partial;

  // pass 0 takes the low word live from the ports; pass 1 the held high word
  always_comb begin
    if (ctl.runSecond) word = swapOut[HALF_W-1:SLICE_W] ^ keyHiHeld;
    else               word = dataIn[SLICE_W-1:0] ^ keyIn[SLICE_W-1:0];
  end

  // slots hold S1,S4,S3,S2; pass 0 feeds x8,x7,x6,x5, pass 1 feeds x1,x4,x3,x2
  always_comb begin
    if (ctl.runSecond) begin
      slotIn[0] = word[31:24];
      slotIn[1] = word[7:0];
      slotIn[2] = word[15:8];
      slotIn[3] = word[23:16];
    end else begin
      for (int s = 0; s < NSLOT; s++) slotIn[s] = word[s*BYTE_W +: BYTE_W];
    end
  end

  generate
    for (genvar g = 0; g < NSLOT; g++) begin : gSlot
      localparam int KIND = (g == 0) ? 1 : (g == 1) ? 4 : (g == 2) ? 3 : 2;
      ff_sbox #(.KIND(KIND)) uBox (.byteIn(slotIn[g]), .byteOut(slotOut[g]));
    end
  endgenerate

  // untouched group enters the linear layer as zero
  always_comb begin
    if (ctl.runSecond)
      yVec = {slotOut[0], slotOut[3], slotOut[2], slotOut[1], {SLICE_W{1'b0}}};
    else
      yVec = {{SLICE_W{1'b0}}, slotOut[3], slotOut[2], slotOut[1], slotOut[0]};
    partial = pLayer(yVec);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resOut    <= '0;
      swapOut   <= '0;
      keyHiHeld <= '0;
    end else if (ctl.loadFirst) begin
      resOut    <= partial ^ (roundMode ? rightIn : {HALF_W{1'b0}});
      swapOut   <= dataIn;
      keyHiHeld <= keyIn[HALF_W-1:SLICE_W];
    end else if (ctl.runSecond) begin
      resOut    <= resOut ^ partial;
    end
  end

  AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!ctl.loadFirst && !ctl.runSecond) |=> $stable(resOut)); // R9
  AST_SWAP_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !ctl.loadFirst |=> $stable(swapOut)); // R9
endmodule

// File: rtl/feistel_f_unit.sv
module feistel_f_unit (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic        roundMode,
  input  logic [63:0] dataIn,
  input  logic [63:0] keyIn,
  input  logic [63:0] rightIn,
  output logic        done,
  output logic        busy,
  output logic [63:0] resOut,
  output logic [63:0] swapOut
);
  import feistel_f_pkg::*;

  ffCtl_t ctl;

  ff_ctrl uCtrl (
    .clk(clk), .rst(rst), .start(start),
    .ctl(ctl), .busy(busy), .done(done)
  );

  ff_datapath uPath (
    .clk(clk), .rst(rst), .ctl(ctl), .roundMode(roundMode),
    .dataIn(dataIn), .keyIn(keyIn), .rightIn(rightIn),
    .resOut(resOut), .swapOut(swapOut)
  );
endmodule

// File: tb/feistel_f_unit_test.sv
`timescale 1ns/1ps
module feistel_f_unit_test;
  logic        clk = 1'b0;
  logic        rst, start, roundMode;
  logic [63:0] dataIn, keyIn, rightIn;
  logic        done, busy;
  logic [63:0] resOut, swapOut;

  int checks = 0;
  int errors = 0;
  logic [7:0] invTab [256];

  always #2.5 clk = ~clk;

  feistel_f_unit uut (
    .clk(clk), .rst(rst), .start(start), .roundMode(roundMode),
    .dataIn(dataIn), .keyIn(keyIn), .rightIn(rightIn),
    .done(done), .busy(busy), .resOut(resOut), .swapOut(swapOut)
  );

  // polynomial product then long-division reduction
  function automatic logic [7:0] refMul(input logic [7:0] a, input logic [7:0] b);
    logic [14:0] p = '0;
    for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (15'(a) << i);
    for (int i = 14; i >= 8; i--) if (p[i]) p = p ^ (15'h11B << (i - 8));
    return p[7:0];
  endfunction

  function automatic logic [7:0] s1(input logic [7:0] a);
    return invTab[a] ^ 8'h6E;
  endfunction

  function automatic logic [7:0] refBox(input int kind, input logic [7:0] a);
    logic [7:0] t;
    case (kind)
      2: begin t = s1(a); return {t[6:0], t[7]}; end
      3: begin t = s1(a); return {t[0], t[7:1]}; end
      4: return s1({a[6:0], a[7]});
      default: return s1(a);
    endcase
  endfunction

  function automatic logic [63:0] refF(input logic [63:0] x, input logic [63:0] k);
    logic [63:0] z = x ^ k;
    logic [7:0] y [1:8];
    int kinds [1:8] = '{1, 2, 3, 4, 2, 3, 4, 1};
    for (int i = 1; i <= 8; i++) y[i] = refBox(kinds[i], z[(8-i)*8 +: 8]);
    return {y[1]^y[3]^y[4]^y[6]^y[7]^y[8], y[1]^y[2]^y[4]^y[5]^y[7]^y[8],
            y[1]^y[2]^y[3]^y[5]^y[6]^y[8], y[2]^y[3]^y[4]^y[5]^y[6]^y[7],
            y[1]^y[2]^y[6]^y[7]^y[8],      y[2]^y[3]^y[5]^y[7]^y[8],
            y[3]^y[4]^y[5]^y[6]^y[8],      y[1]^y[4]^y[5]^y[6]^y[7]};
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doOp(input logic [63:0] x, input logic [63:0] k, input logic [63:0] r,
                      input logic mode, input logic inject, input string tag);
    logic [63:0] exp = refF(x, k) ^ (mode ? r : 64'h0);
    @(negedge clk);
    dataIn = x; keyIn = k; rightIn = r; roundMode = mode; start = 1'b1;
    @(negedge clk);
    chk(!done && busy, "R5 busy pass", {62'h0, busy, done}, 64'h2);
    if (inject) begin
      dataIn = ~x; keyIn = ~k; rightIn = ~r; roundMode = ~mode;
    end else start = 1'b0;
    @(negedge clk);
    start = 1'b0;
    chk(done, "R5 done", {63'h0, done}, 64'h1);
    chk(resOut == exp, tag, resOut, exp);
    chk(swapOut == x, "R7 swap", swapOut, x);
    @(negedge clk);
    chk(!done && !busy, inject ? "R6 no extra done" : "R5 single done", {62'h0, busy, done}, 64'h0);
    chk(resOut == exp, "R9 hold", resOut, exp);
  endtask

  initial begin
    for (int a = 0; a < 256; a++) begin
      invTab[a] = 8'h00;
      for (int b = 1; b < 256; b++) if (refMul(8'(a), 8'(b)) == 8'h01) invTab[a] = 8'(b);
    end
    rst = 1'b1; start = 1'b0; roundMode = 1'b0;
    dataIn = '0; keyIn = '0; rightIn = '0;
    repeat (3) @(negedge clk);
    // R8: reset state
    chk(!done && !busy && resOut == 0 && swapOut == 0, "R8 reset", resOut, 64'h0);
    rst = 1'b0;
    // R2 R3 R4: every byte position through every value, key zero
    for (int pos = 0; pos < 8; pos++)
      for (int v = 0; v < 256; v++)
        doOp(64'(v) << (8*pos), 64'h0, 64'h0, 1'b0, 1'b0, "R3 data sweep");
    // R1: same sweep on the key with zero data
    for (int pos = 0; pos < 8; pos++)
      for (int v = 0; v < 256; v++)
        doOp(64'h0, 64'(v) << (8*pos), 64'h0, 1'b0, 1'b0, "R1 key sweep");
    // R7 R4: random values in both modes
    for (int i = 0; i < 200; i++)
      doOp({$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom},
           1'(i), 1'b0, "R7 random round");
    // R6: start held high through the busy cycle
    for (int i = 0; i < 50; i++)
      doOp({$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom},
           1'(i), 1'b1, "R6 busy start");
    // R8: reset clears a loaded result
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk(!done && resOut == 0 && swapOut == 0, "R8 reset after use", resOut, 64'h0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=%h expected=%h", 64'h0, 64'h1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule